// File: doc/BRIEF.md
# Register-Stepped Serial EEPROM Responder

This block plays the device side of a small three-wire serial EEPROM whose serial line is not clocked by a pin. Every step of the serial protocol is instead taken by a host register access. A host drives the protocol in software through two byte-wide register strobes, a data register and a direction register. It can also read the data register back to sample the device's serial output. Each accepted data-register write carries one serial input bit. Each data-register read during a read command returns one serial output bit.

A transaction consists of a start bit, a two-bit opcode and a six-bit word address, each sent most significant bit first. The block then moves 16-bit words out of (read) or into (write) an internal array of 64 words. After each complete word it steps the word address by one, wrapping from the last word back to word 0. Reads begin with one dummy zero bit before the first data bit. Reset reloads the array from a parameterised image, so a bench or a system model starts from known contents.

Top module: `eeprom_bitbang_top`

## Requirements
- R1: A data-register or direction-register write takes effect only when bits 7 and 6 of the written value are both 1. Any other write leaves the protocol state, address, bit position and array unchanged.
- R2: An accepted direction-register write whose bits 5:4 are 2'b10 returns the sequencer to the ready state from any state. An accepted direction write with any other value in bits 5:4 changes nothing.
- R3: The sequencer states follow a fixed order: ready, first opcode bit, second opcode bit, six address bits, then a transfer state. The transfer state persists until a direction reset (R2) or a block reset.
- R4: In the ready state, an accepted data write moves to the first opcode state and clears the command, whatever its bit 5 holds. That bit is not used as serial data.
- R5: Serial input is bit 5 of an accepted data write. The first opcode bit becomes command bit 1 and the second becomes command bit 0. Command 2'b10 is read and 2'b01 is write. Commands 2'b00 and 2'b11 neither change the array nor return data.
- R6: The six address bits arrive most significant bit first, one per accepted data write. The first one sets address bit 5 and the last sets address bit 0.
- R7: A data-register read in the transfer state of a read command returns the current word's next bit, starting at bit 15, on bit 4 of the read data, and all other bits read 0. A read at any other time returns 0 and changes nothing.
- R8: The first data-register read after the address of a read command returns 0 and consumes no data bit.
- R9: After bit 0 of a word has been transferred, the word address increments and the next transfer starts at bit 15. Address 63 wraps to 0.
- R10: In the transfer state of a write command, each accepted data write stores its bit 5 into the current word, starting at bit 15, with no dummy step.
- R11: Synchronous active-high reset puts the sequencer in the ready state, clears the read data and loads word i of the array with `INIT_SEED ^ (i * 16'h0421)` truncated to 16 bits.
- R12: The read data output is registered. It takes the value of a read one clock after the read strobe and holds it until the next read strobe. At most one of the three strobes is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_wr | input | 1 | Data-register write strobe |
| dir_wr | input | 1 | Direction-register write strobe |
| rd_en | input | 1 | Data-register read strobe |
| wdata | input | 8 | Value written with either write strobe |
| rdata | output | 16 | Registered data-register read value |

## Verification
The hardest situation to reach is the word boundary combined with the address wrap. The read stream has to cross from word 63 into word 0, and the single dummy read must come only once, at the start of the stream. The stimulus issues a read command at address 62 and pulls 48 bits straight through without restarting, checking three whole words against the reset image. A write command is likewise left open across two words, and the array is read back afterwards. Guarded, non-resetting direction writes and reads are injected in the middle of live transfers. Those runs check that the stream continues exactly where it stood.

// File: rtl/eeprom_bb_pkg.sv
package eeprom_bb_pkg;
  // bit positions inside the 8-bit host register values
  localparam int GUARD_HI = 7;
  localparam int GUARD_LO = 6;
  localparam int SER_IN   = 5;
  localparam int MODE_HI  = 5;
  localparam int MODE_LO  = 4;
  localparam int SER_OUT  = 4;

  localparam logic [1:0] CMD_NONE  = 2'b00;
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] CMD_READ  = 2'b10;
  localparam logic [1:0] MODE_RESTART = 2'b10;

  typedef enum logic [2:0] {
    ST_READY,
    ST_OP_HI,
    ST_OP_LO,
    ST_ADDR,
    ST_XFER
  } seq_state_t;
endpackage

// File: rtl/eeprom_bb_seq.sv
module eeprom_bb_seq
  import eeprom_bb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 6,
  parameter int REG_W  = 8,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int AC_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr,
  input  logic              dir_wr,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BIT_W-1:0]  bit_pos,
  output logic              mem_we,
  output logic              mem_wbit,
  output logic              rd_hit
);
  localparam logic [AC_W-1:0]  A_LAST = AC_W'(ADDR_W - 1);
  localparam logic [BIT_W-1:0] B_LAST = BIT_W'(WORD_W - 1);

  seq_state_t          state;
  logic [1:0]          cmd;
  logic [ADDR_W-1:0]   addr;
  logic [AC_W-1:0]     acnt;
  logic [BIT_W-1:0]    bidx;
  logic                dummy;

  logic guard_ok, dat_ok, dir_ok, restart, din, in_rd, in_wr, adv;
  logic [BIT_W-1:0] eff;

  assign guard_ok = wdata[GUARD_HI] & wdata[GUARD_LO];
  assign dat_ok   = dat_wr & guard_ok;
  assign dir_ok   = dir_wr & guard_ok;
  assign restart  = dir_ok & (wdata[MODE_HI:MODE_LO] == MODE_RESTART);
  assign din      = wdata[SER_IN];
  assign in_rd    = (state == ST_XFER) && (cmd == CMD_READ);
  assign in_wr    = (state == ST_XFER) && (cmd == CMD_WRITE);
  // writes never take a dummy step; a pending one is simply dropped
  assign eff      = (in_wr && dummy) ? '0 : bidx;
  assign rd_hit   = rd_en & in_rd & ~dummy;
  assign mem_we   = dat_ok & in_wr & ~restart;
  assign mem_wbit = din;
  assign adv      = mem_we | rd_hit;
  assign word_addr = addr;
  assign bit_pos   = eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_READY;
      cmd   <= CMD_NONE;
      addr  <= '0;
      acnt  <= '0;
      bidx  <= '0;
      dummy <= 1'b0;
    end else if (restart) begin
      state <= ST_READY;
    end else begin
      if (dat_ok) begin
        unique case (state)
          ST_READY: begin
            cmd   <= CMD_NONE;
            state <= ST_OP_HI;
          end
          ST_OP_HI: begin
            cmd[1] <= din;
            dummy  <= 1'b1;
            bidx   <= '0;
            state  <= ST_OP_LO;
          end
          ST_OP_LO: begin
            cmd[0] <= din;
            acnt   <= '0;
            state  <= ST_ADDR;
          end
          ST_ADDR: begin
            addr[A_LAST - acnt] <= din;
            if (acnt == A_LAST) state <= ST_XFER;
            else acnt <= acnt + 1'b1;
          end
          default: begin
            if (in_wr) dummy <= 1'b0;
          end
        endcase
      end
      if (rd_en && in_rd && dummy) dummy <= 1'b0;
      if (adv) begin
        if (eff == B_LAST) begin
          bidx <= '0;
          addr <= addr + 1'b1;
        end else begin
          bidx <= eff + 1'b1;
        end
      end
    end
  end

  // R12: host strobes never overlap
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $countones({dat_wr, dir_wr, rd_en}) <= 1);
  // R1: rejected writes leave the sequencer untouched
  assert_guard_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ((dat_wr || dir_wr) && !guard_ok) |=> ($stable(state) && $stable(addr) && $stable(bidx)));
  // R2: restart lands in ready
  assert_restart_ready_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (state == ST_READY));
  // R3: transfer state is sticky
  assert_xfer_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && !restart) |=> (state == ST_XFER));
  // R9: finishing the last bit of a word moves to the next word
  assert_word_step_R9: assert property (@(posedge clk) disable iff (rst)
    (adv && eff == B_LAST) |=> (addr == $past(addr) + 1'b1 && bidx == '0));
endmodule

// File: rtl/eeprom_bb_store.sv
module eeprom_bb_store #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 6,
  parameter logic [15:0] INIT_SEED = 16'h5AC3,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bit_pos,
  input  logic              we,
  input  logic              wbit,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= WORD_W'(INIT_SEED) ^ WORD_W'(i * 32'h0421);
    end else if (we) begin
      mem[addr][WORD_W-1-int'(bit_pos)] <= wbit;
    end
  end

  assign word = mem[addr];
endmodule

// File: rtl/eeprom_bitbang_top.sv
module eeprom_bitbang_top
  import eeprom_bb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 6,
  parameter int REG_W  = 8,
  parameter logic [15:0] INIT_SEED = 16'h5AC3,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr,
  input  logic              dir_wr,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [ADDR_W-1:0] word_addr;
  logic [BIT_W-1:0]  bit_pos;
  logic              mem_we, mem_wbit, rd_hit;
  logic [WORD_W-1:0] cur_word;

  eeprom_bb_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) seq_i (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .dir_wr(dir_wr), .rd_en(rd_en),
    .wdata(wdata), .word_addr(word_addr), .bit_pos(bit_pos),
    .mem_we(mem_we), .mem_wbit(mem_wbit), .rd_hit(rd_hit)
  );

  eeprom_bb_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .INIT_SEED(INIT_SEED)) store_i (
    .clk(clk), .rst(rst), .addr(word_addr), .bit_pos(bit_pos),
    .we(mem_we), .wbit(mem_wbit), .word(cur_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (rd_hit) rdata[SER_OUT] <= cur_word[WORD_W-1-int'(bit_pos)];
    end
  end

  // R7: only the serial-out bit can ever be set
  assert_out_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~(WORD_W'(1) << SER_OUT)) == '0);
  // R12: output holds between reads
  assert_out_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R7: a read that delivers no data bit returns zero
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> (rdata == '0));
endmodule

// File: tb/eeprom_bitbang_top_tb_top.sv
module eeprom_bitbang_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dat_wr = 1'b0, dir_wr = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  int total = 0, bad = 0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  eeprom_bitbang_top dut_i (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .dir_wr(dir_wr),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); wdata = v; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wr_dir(input logic [7:0] v);
    @(negedge clk); wdata = v; dir_wr = 1'b1;
    @(negedge clk); dir_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic send_bit(input logic b);
    wr_dat(8'hC0 | (8'(b) << 5));
  endtask

  // restart, start bit, opcode, six address bits
  task automatic start_cmd(input logic [1:0] op, input logic [5:0] a);
    wr_dir(8'hE0);
    send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 5; i >= 0; i--) send_bit(a[i]);
  endtask

  // 16 reads assembled MSB first; stray bits reported under R7
  task automatic read_word(output logic [15:0] w);
    logic [15:0] v;
    logic [15:0] stray;
    stray = '0;
    for (int i = 15; i >= 0; i--) begin
      rd(v);
      w[i] = v[4];
      stray |= v & 16'hFFEF;
    end
    chk("R7 other bits zero", stray, 16'h0000);
  endtask

  task automatic write_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic t_reset;
    logic [15:0] v, w;
    chk("R11 rdata after reset", rdata, 16'h0000);
    start_cmd(2'b10, 6'd0);
    rd(v);
    chk("R8 dummy read", v, 16'h0000);
    read_word(w);
    chk("R11 image word 0", w, model[0]);
    read_word(w);
    chk("R9 next word 1", w, model[1]);
  endtask

  task automatic t_wrap;
    logic [15:0] v, w;
    start_cmd(2'b10, 6'd62);
    rd(v);
    chk("R8 dummy at 62", v, 16'h0000);
    read_word(w);
    chk("R6 word 62", w, model[62]);
    read_word(w);
    chk("R9 word 63", w, model[63]);
    read_word(w);
    chk("R9 wrap to 0", w, model[0]);
  endtask

  task automatic t_write;
    logic [15:0] v, w;
    start_cmd(2'b01, 6'd5);
    write_word(16'h1234);
    write_word(16'hBEEF);
    model[5] = 16'h1234; model[6] = 16'hBEEF;
    start_cmd(2'b10, 6'd5);
    rd(v);
    read_word(w);
    chk("R10 written word 5", w, model[5]);
    read_word(w);
    chk("R10 auto-increment word 6", w, model[6]);
    read_word(w);
    chk("R10 word 7 untouched", w, model[7]);
  endtask

  task automatic t_guard;
    logic [15:0] v, w;
    start_cmd(2'b01, 6'd10);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    wr_dat(8'h60); wr_dat(8'hA0); wr_dat(8'h20);
    wr_dir(8'h60);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    model[10] = 16'h00FF;
    start_cmd(2'b10, 6'd10);
    rd(v);
    for (int i = 0; i < 8; i++) begin
      rd(v);
      w[15-i] = v[4];
    end
    wr_dir(8'h20);
    wr_dat(8'h60);
    for (int i = 8; i < 16; i++) begin
      rd(v);
      w[15-i] = v[4];
    end
    chk("R1 unguarded writes ignored", w, 16'h00FF);
  endtask

  task automatic t_restart;
    logic [15:0] v, w;
    wr_dir(8'hE0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    wr_dir(8'hE0);
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 5; i >= 0; i--) send_bit(3'd3 >> i);
    rd(v);
    chk("R4 ready ignores bit value", v, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      rd(v);
      w[15-i] = v[4];
    end
    wr_dir(8'hD0);
    wr_dir(8'hF0);
    for (int i = 8; i < 16; i++) begin
      rd(v);
      w[15-i] = v[4];
    end
    chk("R2 restart mid-address, other modes inert", w, model[3]);
    wr_dir(8'hE0);
    rd(v);
    chk("R7 read in ready is zero", v, 16'h0000);
  endtask

  task automatic t_odd_cmds;
    logic [15:0] v, w;
    start_cmd(2'b11, 6'd7);
    write_word(16'hFFFF);
    rd(v);
    chk("R5 cmd 11 returns no data", v, 16'h0000);
    start_cmd(2'b00, 6'd7);
    write_word(16'hFFFF);
    rd(v);
    chk("R5 cmd 00 returns no data", v, 16'h0000);
    start_cmd(2'b01, 6'd20);
    for (int i = 15; i >= 8; i--) send_bit(i[0]);
    rd(v);
    chk("R7 read during write cmd", v, 16'h0000);
    for (int i = 7; i >= 0; i--) send_bit(i[0]);
    model[20] = 16'hAAAA;
    start_cmd(2'b10, 6'd7);
    rd(v);
    read_word(w);
    chk("R5 word 7 unchanged", w, model[7]);
    start_cmd(2'b10, 6'd20);
    rd(v);
    read_word(w);
    chk("R7 write stream not shifted by read", w, model[20]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h5AC3 ^ 16'(i * 32'h0421);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_write();
    t_guard();
    t_restart();
    t_odd_cmds();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule